// File: doc/BRIEF.md
# BERT Receive Performance Counters

This block gathers receive-side statistics for a bit-error-rate tester. One counter tallies every received bit flagged by a bit-valid strobe. A second counter tallies the bits that the upstream comparator marks as mismatched against the expected pattern. While the pattern detector reports loss of synchronization, both counters hold their values. Neither counter wraps: each stops at its all-ones value.

Software never reads the live counters. A performance-monitor update strobe copies both live counts into holding registers and restarts the live counters from zero. A bit that arrives in the same cycle as the strobe is counted in the new interval. The holding registers are read through a 16-bit register port. Reads have no side effects.

The received-bit stream is a plain strobe with no ready signal. The block accepts a bit on every cycle in which `bit_vld` is high and never applies back-pressure. The upstream source is therefore never stalled.

Top module: `bert_rx_perf`

## Requirements
- R1: After reset, every readable count register returns zero.
- R2: The live bit count rises by one in each cycle where `bit_vld` is high and `out_of_sync` is low.
- R3: The live error count rises by one only in cycles where `bit_vld` and `bit_err` are both high and `out_of_sync` is low. The error count therefore never exceeds the bit count.
- R4: While `out_of_sync` is high, neither live counter changes. The only exception is the restart caused by `pm_update`.
- R5: The error counter (ERR_W bits, 24 by default) holds at 2^ERR_W-1 (FF_FFFFh by default) and does not wrap.
- R6: The bit counter (BIT_W bits, 32 by default) holds at 2^BIT_W-1 (FFFF_FFFFh by default) and does not wrap.
- R7: The holding registers, and therefore all read data, change only in a cycle that follows a `pm_update` pulse. Repeated reads return the same value.
- R8: On `pm_update`, the holding registers take the live counts as they stood before that cycle's bit. Each live counter then restarts at 1 if it counts that cycle's bit, and at 0 otherwise.
- R9: The register map is as follows:
  - Address 74h returns error count bits 15:0.
  - Address 76h returns error count bits 23:16 in data bits 7:0, with data bits 15:8 reading zero.
  - Address 78h returns bit count bits 15:0.
  - Address 7Ah returns bit count bits 31:16.
  - Any other address reads zero.
  - Counts narrower than these fields are zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld | input | 1 | One received bit this cycle |
| bit_err | input | 1 | That bit mismatched the expected pattern |
| out_of_sync | input | 1 | Pattern detector is out of synchronization |
| pm_update | input | 1 | Performance-monitor update strobe |
| reg_addr | input | ADDR_W | Register read address |
| reg_rdata | output | 16 | Read data from the holding registers |

## Verification
The counters are driven with several input mixes, and each mix separates a different fault:
- Valid bits with sparse errors tell the bit path apart from the error path.
- A run with `out_of_sync` high, carrying both valid bits and errors, exposes any leak through the freeze.
- A strobe that coincides with a valid errored bit shows whether that bit lands in the old interval or the new one.
- A long errored run pushes the default-width counts past 16 bits, which checks the high words.
- The same run saturates a second, narrow-width instance, which separates saturation from wrapping.

// File: rtl/bert_perf_pkg.sv
package bert_perf_pkg;
  localparam int RD_W = 16;
  localparam logic [7:0] OFS_ERR_LO = 8'h74;
  localparam logic [7:0] OFS_ERR_HI = 8'h76;
  localparam logic [7:0] OFS_BIT_LO = 8'h78;
  localparam logic [7:0] OFS_BIT_HI = 8'h7A;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ERR_LO,
    SEL_ERR_HI,
    SEL_BIT_LO,
    SEL_BIT_HI
  } rd_sel_e;
endpackage

// File: rtl/bert_sat_cnt.sv
module bert_sat_cnt #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         restart,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] CNT_MAX = '1;
  localparam logic [W-1:0] CNT_ONE = W'(1);

  logic at_max;
  assign at_max = (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart) begin
      cnt <= inc ? CNT_ONE : '0;
    end else if (inc && !at_max) begin
      cnt <= cnt + CNT_ONE;
    end
  end
endmodule

// File: rtl/bert_snap.sv
module bert_snap #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else if (load) begin
      q <= din;
    end
  end
endmodule

// File: rtl/bert_reg_mux.sv
module bert_reg_mux
  import bert_perf_pkg::*;
#(
  parameter int ERR_W  = 24,
  parameter int BIT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ERR_W-1:0]  errs,
  input  logic [BIT_W-1:0]  bits,
  output logic [RD_W-1:0]   rdata
);
  logic [23:0] err_x;
  logic [31:0] bit_x;
  rd_sel_e     sel;

  assign err_x = 24'(errs);
  assign bit_x = 32'(bits);

  always_comb begin
    if (addr == ADDR_W'(OFS_ERR_LO))      sel = SEL_ERR_LO;
    else if (addr == ADDR_W'(OFS_ERR_HI)) sel = SEL_ERR_HI;
    else if (addr == ADDR_W'(OFS_BIT_LO)) sel = SEL_BIT_LO;
    else if (addr == ADDR_W'(OFS_BIT_HI)) sel = SEL_BIT_HI;
    else                                  sel = SEL_NONE;
  end

  always_comb begin
    unique case (sel)
      SEL_ERR_LO: rdata = err_x[15:0];
      SEL_ERR_HI: rdata = {8'h00, err_x[23:16]};
      SEL_BIT_LO: rdata = bit_x[15:0];
      SEL_BIT_HI: rdata = bit_x[31:16];
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/bert_rx_perf.sv
module bert_rx_perf
  import bert_perf_pkg::*;
#(
  parameter int ERR_W  = 24,
  parameter int BIT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_vld,
  input  logic              bit_err,
  input  logic              out_of_sync,
  input  logic              pm_update,
  input  logic [ADDR_W-1:0] reg_addr,
  output logic [15:0]       reg_rdata
);
  logic             bit_en;
  logic             err_en;
  logic [BIT_W-1:0] live_bits;
  logic [ERR_W-1:0] live_errs;
  logic [BIT_W-1:0] hold_bits;
  logic [ERR_W-1:0] hold_errs;

  assign bit_en = bit_vld & ~out_of_sync;
  assign err_en = bit_en & bit_err;

  bert_sat_cnt #(.W(BIT_W)) u_bit_cnt (
    .clk(clk), .rst_n(rst_n), .inc(bit_en), .restart(pm_update), .cnt(live_bits)
  );

  bert_sat_cnt #(.W(ERR_W)) u_err_cnt (
    .clk(clk), .rst_n(rst_n), .inc(err_en), .restart(pm_update), .cnt(live_errs)
  );

  bert_snap #(.W(BIT_W)) u_bit_hold (
    .clk(clk), .rst_n(rst_n), .load(pm_update), .din(live_bits), .q(hold_bits)
  );

  bert_snap #(.W(ERR_W)) u_err_hold (
    .clk(clk), .rst_n(rst_n), .load(pm_update), .din(live_errs), .q(hold_errs)
  );

  bert_reg_mux #(.ERR_W(ERR_W), .BIT_W(BIT_W), .ADDR_W(ADDR_W)) u_mux (
    .addr(reg_addr), .errs(hold_errs), .bits(hold_bits), .rdata(reg_rdata)
  );
endmodule

// File: rtl/bert_rx_perf_chk.sv
module bert_rx_perf_chk #(
  parameter int ERR_W = 24,
  parameter int BIT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_vld,
  input logic             bit_err,
  input logic             out_of_sync,
  input logic             pm_update,
  input logic [BIT_W-1:0] live_bits,
  input logic [ERR_W-1:0] live_errs,
  input logic [BIT_W-1:0] hold_bits,
  input logic [ERR_W-1:0] hold_errs
);
  // R2
  bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && !out_of_sync && !pm_update && live_bits != '1)
      |=> live_bits == $past(live_bits) + BIT_W'(1));

  // R3
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!bit_err || !bit_vld || out_of_sync) && !pm_update) |=> $stable(live_errs));

  // R3
  err_le_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    64'(live_errs) <= 64'(live_bits));

  // R4
  oos_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_of_sync && !pm_update) |=> ($stable(live_bits) && $stable(live_errs)));

  // R5
  err_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_errs == '1 && !pm_update) |=> live_errs == '1);

  // R6
  bit_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_bits == '1 && !pm_update) |=> live_bits == '1);

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pm_update |=> ($stable(hold_bits) && $stable(hold_errs)));

  // R8
  snap_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pm_update |=> (hold_bits == $past(live_bits) && hold_errs == $past(live_errs)
                   && live_bits <= BIT_W'(1)));
endmodule

bind bert_rx_perf bert_rx_perf_chk #(.ERR_W(ERR_W), .BIT_W(BIT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_err(bit_err),
  .out_of_sync(out_of_sync), .pm_update(pm_update),
  .live_bits(live_bits), .live_errs(live_errs),
  .hold_bits(hold_bits), .hold_errs(hold_errs)
);

// File: tb/test_bert_rx_perf.sv
`timescale 1ns/1ps
module test_bert_rx_perf;
  localparam int SE_W = 4;
  localparam int SB_W = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_vld = 1'b0, bit_err = 1'b0, out_of_sync = 1'b0, pm_update = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [15:0] rdata_main, rdata_sat;

  always #4 clk = ~clk;

  bert_rx_perf i_bert_rx_perf (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_err(bit_err),
    .out_of_sync(out_of_sync), .pm_update(pm_update),
    .reg_addr(reg_addr), .reg_rdata(rdata_main)
  );

  bert_rx_perf #(.ERR_W(SE_W), .BIT_W(SB_W)) i_sat (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_err(bit_err),
    .out_of_sync(out_of_sync), .pm_update(pm_update),
    .reg_addr(reg_addr), .reg_rdata(rdata_sat)
  );

  // Behavioural reference: live and held counts per instance
  longint m_lb, m_le, m_hb, m_he;
  longint s_lb, s_le, s_hb, s_he;
  localparam longint M_BMAX = (longint'(1) << 32) - 1;
  localparam longint M_EMAX = (longint'(1) << 24) - 1;
  localparam longint S_BMAX = (longint'(1) << SB_W) - 1;
  localparam longint S_EMAX = (longint'(1) << SE_W) - 1;

  always @(posedge clk) begin
    automatic bit en = bit_vld && !out_of_sync;
    automatic bit ee = en && bit_err;
    if (!rst_n) begin
      m_lb = 0; m_le = 0; m_hb = 0; m_he = 0;
      s_lb = 0; s_le = 0; s_hb = 0; s_he = 0;
    end else if (pm_update) begin
      m_hb = m_lb; m_he = m_le; s_hb = s_lb; s_he = s_le;
      m_lb = en ? 1 : 0; s_lb = m_lb;
      m_le = ee ? 1 : 0; s_le = m_le;
    end else begin
      if (en && m_lb < M_BMAX) m_lb++;
      if (ee && m_le < M_EMAX) m_le++;
      if (en && s_lb < S_BMAX) s_lb++;
      if (ee && s_le < S_EMAX) s_le++;
    end
  end

  function automatic logic [15:0] exp_rd(logic [7:0] a, longint hb, longint he);
    case (a)
      8'h74:   return he[15:0];
      8'h76:   return {8'h00, he[23:16]};
      8'h78:   return hb[15:0];
      8'h7A:   return hb[31:16];
      default: return 16'h0000;
    endcase
  endfunction

  function automatic string tag_of(logic [7:0] a);
    case (a)
      8'h74, 8'h76: return "R3";
      8'h78, 8'h7A: return "R2";
      default:      return "R9";
    endcase
  endfunction

  // Per-cycle comparison against the reference
  int  cyc_chk = 0, cyc_err = 0;
  bit  cmp_on = 1'b0;
  always @(negedge clk) begin
    if (cmp_on) begin
      automatic logic [15:0] em = exp_rd(reg_addr, m_hb, m_he);
      automatic logic [15:0] es = exp_rd(reg_addr, s_hb, s_he);
      cyc_chk += 2;
      if (rdata_main !== em) begin
        cyc_err++;
        $display("FAIL %s main addr=%h got=%h exp=%h", tag_of(reg_addr), reg_addr, rdata_main, em);
      end
      if (rdata_sat !== es) begin
        cyc_err++;
        $display("FAIL %s sat addr=%h got=%h exp=%h", tag_of(reg_addr), reg_addr, rdata_sat, es);
      end
    end
  end

  int dir_chk = 0, dir_err = 0;
  int rot = 0;

  task automatic step(input logic v, input logic e, input logic o, input logic u);
    @(posedge clk);
    #1;
    bit_vld = v; bit_err = e; out_of_sync = o; pm_update = u;
    rot = (rot + 1) % 5;
    case (rot)
      0: reg_addr = 8'h74;
      1: reg_addr = 8'h76;
      2: reg_addr = 8'h78;
      3: reg_addr = 8'h7A;
      default: reg_addr = 8'h7C;
    endcase
  endtask

  task automatic peek(input logic [7:0] a, input bit use_sat, input logic [15:0] exp,
                      input string tag);
    @(posedge clk);
    #1;
    bit_vld = 0; bit_err = 0; out_of_sync = 0; pm_update = 0; reg_addr = a;
    @(negedge clk);
    dir_chk++;
    if ((use_sat ? rdata_sat : rdata_main) !== exp) begin
      dir_err++;
      $display("FAIL %s addr=%h got=%h exp=%h", tag, a,
               use_sat ? rdata_sat : rdata_main, exp);
    end
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        cmp_on = 1'b1;
        // R1: reset values
        peek(8'h74, 0, 16'h0, "R1");
        peek(8'h76, 0, 16'h0, "R1");
        peek(8'h78, 0, 16'h0, "R1");
        peek(8'h7A, 0, 16'h0, "R1");
        // 10 bits with 3 errors, no update: held values unchanged (R7)
        for (int i = 0; i < 10; i++) step(1, (i % 3) == 0 && i < 9, 0, 0);
        peek(8'h78, 0, 16'h0, "R7");
        step(0, 0, 0, 1);
        peek(8'h78, 0, 16'd10, "R2");
        peek(8'h74, 0, 16'd3, "R3");
        peek(8'h78, 0, 16'd10, "R7");
        // R4: out-of-sync freezes both counters
        for (int i = 0; i < 5; i++) step(1, 1, 1, 0);
        step(0, 0, 0, 1);
        peek(8'h78, 0, 16'd0, "R4");
        peek(8'h74, 0, 16'd0, "R4");
        // R8: strobe with an errored bit in the same cycle
        step(1, 1, 0, 1);
        step(1, 0, 0, 0);
        step(1, 0, 0, 0);
        peek(8'h78, 0, 16'd0, "R8");
        step(0, 0, 0, 1);
        peek(8'h78, 0, 16'd3, "R8");
        peek(8'h74, 0, 16'd1, "R8");
        // R5/R6: narrow instance saturates
        for (int i = 0; i < 40; i++) step(1, 1, 0, 0);
        step(0, 0, 0, 1);
        peek(8'h78, 1, 16'd31, "R6");
        peek(8'h74, 1, 16'd15, "R5");
        peek(8'h78, 0, 16'd40, "R2");
        // R9: counts past 16 bits on the default-width instance
        for (int i = 0; i < 70000; i++) step(1, 1, 0, 0);
        step(0, 0, 0, 1);
        peek(8'h74, 0, 16'h1170, "R9");
        peek(8'h76, 0, 16'h0001, "R9");
        peek(8'h78, 0, 16'h1170, "R9");
        peek(8'h7A, 0, 16'h0001, "R9");
        peek(8'h7C, 0, 16'h0000, "R9");
        peek(8'h70, 0, 16'h0000, "R9");
        peek(8'h78, 1, 16'd31, "R6");
        peek(8'h74, 1, 16'd15, "R5");
        repeat (4) step(0, 0, 0, 0);
      end
      begin
        repeat (200000) @(posedge clk);
        dir_chk++;
        dir_err++;
        $display("FAIL watchdog got=timeout exp=done");
      end
    join_any
    disable fork;
    cmp_on = 1'b0;
    $display("Result: errors=%0d of %0d checks", dir_err + cyc_err, dir_chk + cyc_chk);
    $finish;
  end
endmodule